// File: doc/BRIEF.md
# Multi-Polynomial Byte-Serial CRC Engine

This block keeps a running cyclic redundancy checksum over a stream of data writes. A control write picks one of three fixed generator polynomials (two 16-bit, one 32-bit) and a set of optional transforms. A seed write sets the starting value. Every later data write extends the same checksum. Writes can be a byte, a half-word or a full word, and the engine folds one byte into the checksum per clock cycle. The checksum read port is combinational from the stored state.

The input transforms act on the data before it enters the checksum: one's complement, reversal of byte order, and bit reversal inside each byte. The output transforms act on the value shown on the read port, not on the stored checksum: one's complement, byte-order reversal over the active checksum width, and bit reversal inside each byte. The engine processes one byte per cycle, so a half-word or word write keeps it busy for one or three more cycles. During that time a ready output is low and all writes are refused, so the writer must hold its request until ready returns.

Top module: `crc_engine`

## Requirements
- R1: Mode code 0 selects the 16-bit polynomial 0x8005 and code 1 selects the 16-bit polynomial 0x1021. Codes 2 and 3 select the 32-bit polynomial 0x04C11DB7. The CRC is non-reflected: each byte enters at the checksum MSB, with the byte's MSB first.
- R2: Each accepted data write continues from the checksum that earlier writes left, so a series of writes gives the CRC of the concatenated bytes.
- R3: Size code 0 takes data bits [7:0], code 1 takes bits [15:0], and codes 2 and 3 take all 32 bits. The bytes are consumed from most significant to least significant.
- R4: A control write or a seed write sets the running checksum to the seed; in 16-bit modes only the low 16 seed bits are kept. If a data write is accepted in the same cycle, it folds into that seed using the new control settings.
- R5: A byte write updates the checksum at its own accepting clock edge. After accepting a half-word write, ready is low for 1 cycle; after a word write, for 3 cycles.
- R6: While ready is low, data, control and seed writes are all ignored and have no effect on the checksum or the settings.
- R7: With input byte swap set, the bytes of a half-word or word are consumed least significant first. For byte writes the flag has no effect.
- R8: With input bit reversal set, the bits inside every consumed byte are reversed, for all sizes including byte writes.
- R9: With input complement set, the accepted data bits are inverted before they are consumed.
- R10: The output flags complement the checksum, reverse its byte order over the active width (2 or 4 bytes) and reverse the bits inside each byte. They affect only the read port.
- R11: In 16-bit modes, bits [31:16] of the checksum port read as zero.
- R12: After reset the checksum, seed and control settings are zero (mode 0, no transforms) and ready is high.
- R13: While ready is high and no write is presented, the checksum port holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_mode | input | 2 | Polynomial select code |
| ctl_in_swap | input | 1 | Reverse byte order of input data |
| ctl_in_brev | input | 1 | Reverse bits within each input byte |
| ctl_in_inv | input | 1 | Complement input data |
| ctl_out_swap | input | 1 | Reverse byte order of checksum output |
| ctl_out_brev | input | 1 | Reverse bits within each output byte |
| ctl_out_inv | input | 1 | Complement checksum output |
| seed_we | input | 1 | Seed write strobe |
| seed_in | input | 32 | Seed value |
| dat_we | input | 1 | Data write strobe |
| dat_size | input | 2 | Data size code (0 byte, 1 half-word, 2/3 word) |
| dat_in | input | 32 | Right-aligned write data |
| wr_ready | output | 1 | High when writes are accepted |
| csum_out | output | 32 | Checksum after output transforms |

## Verification
On every cycle, assertions check the ready timing for each write size, that the upper half of the port is zero in 16-bit modes, and that the port holds steady while idle. Only the bench scenarios can show checksum values. The bench sweeps all three polynomials, every combination of the six transform flags and every access size. It compares each result with a bit-serial model. It also shows that writes refused while busy leave no trace, and it covers a control, seed and data write landing in the same cycle.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

    localparam int DW     = 32;
    localparam int NB     = DW / 8;
    localparam int CNT_W  = $clog2(NB) + 1;
    localparam logic [15:0] POLY_A = 16'h8005;
    localparam logic [15:0] POLY_B = 16'h1021;
    localparam logic [31:0] POLY_C = 32'h04C1_1DB7;

    typedef enum logic [1:0] {
        PM_A16  = 2'd0,
        PM_B16  = 2'd1,
        PM_C32  = 2'd2,
        PM_C32X = 2'd3
    } poly_e;

    typedef struct packed {
        poly_e mode;
        logic  in_swap;
        logic  in_brev;
        logic  in_inv;
        logic  out_swap;
        logic  out_brev;
        logic  out_inv;
    } ctl_t;

    function automatic logic [DW-1:0] rev_bits_in_bytes(input logic [DW-1:0] x);
        logic [DW-1:0] r;
        for (int k = 0; k < NB; k++) begin
            for (int b = 0; b < 8; b++) begin
                r[8*k + b] = x[8*k + 7 - b];
            end
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] rev_bytes(input logic [DW-1:0] x);
        logic [DW-1:0] r;
        for (int k = 0; k < NB; k++) begin
            r[8*k +: 8] = x[8*(NB-1-k) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_in_fmt.sv
module crc_in_fmt
    import crc_eng_pkg::*;
(
    input  logic [DW-1:0]    din,
    input  logic [1:0]       size,
    input  ctl_t             ctl,
    output logic [DW-1:0]    aligned,
    output logic [CNT_W-1:0] nbytes
);
    logic [DW-1:0] mask;
    logic [DW-1:0] v;

    always_comb begin
        case (size)
            2'd0:    begin nbytes = CNT_W'(1); mask = DW'(32'h0000_00FF); end
            2'd1:    begin nbytes = CNT_W'(2); mask = DW'(32'h0000_FFFF); end
            default: begin nbytes = CNT_W'(NB); mask = '1; end
        endcase
        v = din & mask;
        if (ctl.in_inv) begin
            v = v ^ mask;
        end
        if (ctl.in_swap) begin
            if (size == 2'd1) begin
                v = {16'h0000, v[7:0], v[15:8]};
            end else if (size != 2'd0) begin
                v = rev_bytes(v);
            end
        end
        if (ctl.in_brev) begin
            v = rev_bits_in_bytes(v);
        end
        aligned = v << (8 * (NB - int'(nbytes)));
    end
endmodule

// File: rtl/crc_byte_fold.sv
module crc_byte_fold
    import crc_eng_pkg::*;
(
    input  logic [DW-1:0] crc_in,
    input  logic [7:0]    byte_in,
    input  poly_e         mode,
    output logic [DW-1:0] crc_nxt
);
    logic [31:0] w;
    logic [15:0] h;
    logic [15:0] hp;

    always_comb begin
        hp = (mode == PM_A16) ? POLY_A : POLY_B;
        w  = crc_in ^ {byte_in, 24'h000000};
        h  = crc_in[15:0] ^ {byte_in, 8'h00};
        for (int i = 0; i < 8; i++) begin
            w = w[31] ? ((w << 1) ^ POLY_C) : (w << 1);
            h = h[15] ? ((h << 1) ^ hp) : (h << 1);
        end
        crc_nxt = mode[1] ? w : {16'h0000, h};
    end
endmodule

// File: rtl/crc_out_fmt.sv
module crc_out_fmt
    import crc_eng_pkg::*;
(
    input  logic [DW-1:0] crc,
    input  ctl_t          ctl,
    output logic [DW-1:0] csum
);
    logic [DW-1:0] mask;
    logic [DW-1:0] v;

    always_comb begin
        mask = ctl.mode[1] ? '1 : DW'(32'h0000_FFFF);
        v    = crc & mask;
        if (ctl.out_inv) begin
            v = v ^ mask;
        end
        if (ctl.out_swap) begin
            v = ctl.mode[1] ? rev_bytes(v) : {16'h0000, v[7:0], v[15:8]};
        end
        if (ctl.out_brev) begin
            v = rev_bits_in_bytes(v);
        end
        csum = v;
    end
endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_eng_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [1:0]  ctl_mode,
    input  logic        ctl_in_swap,
    input  logic        ctl_in_brev,
    input  logic        ctl_in_inv,
    input  logic        ctl_out_swap,
    input  logic        ctl_out_brev,
    input  logic        ctl_out_inv,
    input  logic        seed_we,
    input  logic [31:0] seed_in,
    input  logic        dat_we,
    input  logic [1:0]  dat_size,
    input  logic [31:0] dat_in,
    output logic        wr_ready,
    output logic [31:0] csum_out
);
    typedef struct packed {
        ctl_t             ctl;
        logic [DW-1:0]    seed;
        logic [DW-1:0]    crc;
        logic [DW-1:0]    sbuf;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_q, st_d;

    ctl_t             ctl_new, ctl_eff;
    logic [DW-1:0]    seed_eff, base_crc;
    logic [DW-1:0]    fmt_aligned;
    logic [CNT_W-1:0] fmt_nbytes;
    logic [DW-1:0]    fold_in, fold_out;
    logic [7:0]       fold_byte;
    poly_e            fold_mode;
    logic             ready_q;

    assign ready_q = (st_q.cnt == '0);

    always_comb begin
        ctl_new.mode     = poly_e'(ctl_mode);
        ctl_new.in_swap  = ctl_in_swap;
        ctl_new.in_brev  = ctl_in_brev;
        ctl_new.in_inv   = ctl_in_inv;
        ctl_new.out_swap = ctl_out_swap;
        ctl_new.out_brev = ctl_out_brev;
        ctl_new.out_inv  = ctl_out_inv;
        ctl_eff  = ctl_we  ? ctl_new : st_q.ctl;
        seed_eff = seed_we ? seed_in : st_q.seed;
        if (ctl_we || seed_we) begin
            base_crc = ctl_eff.mode[1] ? seed_eff : {16'h0000, seed_eff[15:0]};
        end else begin
            base_crc = st_q.crc;
        end
    end

    crc_in_fmt u_in_fmt (
        .din     (dat_in),
        .size    (dat_size),
        .ctl     (ctl_eff),
        .aligned (fmt_aligned),
        .nbytes  (fmt_nbytes)
    );

    always_comb begin
        if (ready_q) begin
            fold_in   = base_crc;
            fold_byte = fmt_aligned[DW-1 -: 8];
            fold_mode = ctl_eff.mode;
        end else begin
            fold_in   = st_q.crc;
            fold_byte = st_q.sbuf[DW-1 -: 8];
            fold_mode = st_q.ctl.mode;
        end
    end

    crc_byte_fold u_fold (
        .crc_in  (fold_in),
        .byte_in (fold_byte),
        .mode    (fold_mode),
        .crc_nxt (fold_out)
    );

    always_comb begin
        st_d = st_q;
        if (ready_q) begin
            st_d.ctl  = ctl_eff;
            st_d.seed = seed_eff;
            st_d.crc  = base_crc;
            if (dat_we) begin
                st_d.crc  = fold_out;
                st_d.sbuf = fmt_aligned << 8;
                st_d.cnt  = fmt_nbytes - CNT_W'(1);
            end
        end else begin
            st_d.crc  = fold_out;
            st_d.sbuf = st_q.sbuf << 8;
            st_d.cnt  = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    crc_out_fmt u_out_fmt (
        .crc  (st_q.crc),
        .ctl  (st_q.ctl),
        .csum (csum_out)
    );

    assign wr_ready = ready_q;

    // R5: a byte write leaves the engine ready on the next cycle
    a_r5_byte_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && dat_we && dat_size == 2'd0) |=> wr_ready);

    // R5: a half-word write holds ready low for exactly one cycle
    a_r5_half_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && dat_we && dat_size == 2'd1) |=> !wr_ready ##1 wr_ready);

    // R5: a word write holds ready low for exactly three cycles
    a_r5_word_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && dat_we && dat_size[1]) |=> !wr_ready ##1 !wr_ready ##1 !wr_ready ##1 wr_ready);

    // R11: upper port half is zero in 16-bit modes
    a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctl.mode[1] |-> csum_out[31:16] == 16'h0000);

    // R13: idle with no writes keeps the port steady
    a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && !dat_we && !ctl_we && !seed_we) |=> $stable(csum_out));

    // R6: settings are frozen while busy
    a_r6_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |=> $stable(st_q.ctl) && $stable(st_q.seed));

endmodule

// File: tb/test_crc_engine.sv
module test_crc_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_mode = 2'd0;
    logic        ctl_in_swap = 1'b0, ctl_in_brev = 1'b0, ctl_in_inv = 1'b0;
    logic        ctl_out_swap = 1'b0, ctl_out_brev = 1'b0, ctl_out_inv = 1'b0;
    logic        seed_we = 1'b0;
    logic [31:0] seed_in = '0;
    logic        dat_we = 1'b0;
    logic [1:0]  dat_size = 2'd0;
    logic [31:0] dat_in = '0;
    logic        wr_ready;
    logic [31:0] csum_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // model state
    logic [31:0] m_crc = '0;
    logic [31:0] m_seed = '0;
    logic [1:0]  m_mode = 2'd0;
    logic [5:0]  m_flags = '0; // {in_swap,in_brev,in_inv,out_swap,out_brev,out_inv}

    always #4 clk = ~clk;

    crc_engine i_crc_engine (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_mode(ctl_mode),
        .ctl_in_swap(ctl_in_swap), .ctl_in_brev(ctl_in_brev), .ctl_in_inv(ctl_in_inv),
        .ctl_out_swap(ctl_out_swap), .ctl_out_brev(ctl_out_brev), .ctl_out_inv(ctl_out_inv),
        .seed_we(seed_we), .seed_in(seed_in),
        .dat_we(dat_we), .dat_size(dat_size), .dat_in(dat_in),
        .wr_ready(wr_ready), .csum_out(csum_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_width_mask(input logic [1:0] md);
        return md[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    // bit-serial reference: one message bit at a time
    function automatic logic [31:0] m_feed(input logic [31:0] c, input logic [7:0] b, input logic [1:0] md);
        logic [31:0] p;
        int w;
        logic fb;
        w = md[1] ? 32 : 16;
        p = md[1] ? 32'h04C11DB7 : (md == 2'd0 ? 32'h8005 : 32'h1021);
        for (int i = 7; i >= 0; i--) begin
            fb = c[w-1] ^ b[i];
            c = c << 1;
            if (fb) c = c ^ p;
            c = c & m_width_mask(md);
        end
        return c;
    endfunction

    function automatic logic [7:0] m_rev8(input logic [7:0] x);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = x[7-i];
        return r;
    endfunction

    function automatic logic [31:0] m_absorb(input logic [31:0] c, input logic [1:0] sz, input logic [31:0] d);
        int n;
        logic [31:0] v, mk;
        logic [7:0] b;
        n  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        mk = (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*n)) - 1);
        v  = d & mk;
        if (m_flags[3]) v = v ^ mk;
        for (int k = 0; k < n; k++) begin
            if (m_flags[5] && n > 1) b = v[8*k +: 8];
            else                     b = v[8*(n-1-k) +: 8];
            if (m_flags[4]) b = m_rev8(b);
            c = m_feed(c, b, m_mode);
        end
        return c;
    endfunction

    function automatic logic [31:0] m_view();
        logic [31:0] v, r;
        int n;
        n = m_mode[1] ? 4 : 2;
        v = m_crc & m_width_mask(m_mode);
        if (m_flags[0]) v = v ^ m_width_mask(m_mode);
        r = v;
        if (m_flags[2]) begin
            r = '0;
            for (int k = 0; k < n; k++) r[8*k +: 8] = v[8*(n-1-k) +: 8];
        end
        if (m_flags[1]) begin
            for (int k = 0; k < 4; k++) r[8*k +: 8] = m_rev8(r[8*k +: 8]);
        end
        return r;
    endfunction

    // one bus transfer; returns cycles ready stayed low afterwards
    task automatic xfer(input bit cw, input logic [1:0] md, input logic [5:0] fl,
                        input bit sw, input logic [31:0] sd,
                        input bit dw, input logic [1:0] sz, input logic [31:0] d,
                        output int busy_cycles);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        ctl_we = cw; ctl_mode = md;
        {ctl_in_swap, ctl_in_brev, ctl_in_inv, ctl_out_swap, ctl_out_brev, ctl_out_inv} = fl;
        seed_we = sw; seed_in = sd;
        dat_we = dw; dat_size = sz; dat_in = d;
        @(negedge clk);
        ctl_we = 1'b0; seed_we = 1'b0; dat_we = 1'b0;
        if (cw) begin m_mode = md; m_flags = fl; end
        if (sw) m_seed = sd;
        if (cw || sw) m_crc = m_seed & m_width_mask(m_mode);
        if (dw) m_crc = m_absorb(m_crc, sz, d);
        busy_cycles = 0;
        while (!wr_ready) begin
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        int bc;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 reset csum", csum_out, 32'h0);
        chk("R12 reset ready", {31'b0, wr_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R7 R8 R9 R10 R11: full sweep
        for (int md = 0; md < 3; md++) begin
            for (int fl = 0; fl < 64; fl++) begin
                xfer(1'b1, 2'(md), 6'(fl), 1'b1, 32'hA5C3_1E77 ^ 32'(fl * 32'h0101_0101), 1'b0, 2'd0, 32'h0, bc);
                chk("R4 seed load", csum_out, m_view());
                xfer(1'b0, 2'(md), 6'(fl), 1'b0, 32'h0, 1'b1, 2'd0, 32'hFFFF_FF00 | 32'(fl + 8'h3C), bc);
                chk("R1 R3 R8 byte write", csum_out, m_view());
                chk("R5 byte busy", 32'(bc), 32'd0);
                xfer(1'b0, 2'(md), 6'(fl), 1'b0, 32'h0, 1'b1, 2'd1, 32'hDEAD_0000 | 32'(fl * 977), bc);
                chk("R2 R7 half write", csum_out, m_view());
                chk("R5 half busy", 32'(bc), 32'd1);
                xfer(1'b0, 2'(md), 6'(fl), 1'b0, 32'h0, 1'b1, 2'd2, 32'h1234_5678 + 32'(fl * 32'h0F1E_2D3C), bc);
                chk("R9 R10 word write", csum_out, m_view());
                chk("R5 word busy", 32'(bc), 32'd3);
                if (md < 2) chk("R11 upper zero", {16'h0, csum_out[31:16]}, 32'h0);
            end
        end

        // R1: size code 3 acts as word
        xfer(1'b1, 2'd3, 6'd0, 1'b1, 32'hFFFF_FFFF, 1'b1, 2'd3, 32'h3132_3334, bc);
        chk("R1 code3 word", csum_out, m_view());

        // R6: writes while busy are ignored
        @(negedge clk);
        ctl_we = 1'b0; seed_we = 1'b0;
        dat_we = 1'b1; dat_size = 2'd2; dat_in = 32'hCAFE_F00D;
        m_crc = m_absorb(m_crc, 2'd2, 32'hCAFE_F00D);
        @(negedge clk);
        dat_we = 1'b0;
        chk("R6 busy after word", {31'b0, wr_ready}, 32'h0);
        ctl_we = 1'b1; ctl_mode = 2'd0; seed_we = 1'b1; seed_in = 32'h0000_1111;
        dat_we = 1'b1; dat_size = 2'd0; dat_in = 32'h55;
        @(negedge clk);
        ctl_we = 1'b0; seed_we = 1'b0; dat_we = 1'b0;
        while (!wr_ready) @(negedge clk);
        chk("R6 ignored writes", csum_out, m_view());

        // R4: ctl, seed and data together
        xfer(1'b1, 2'd1, 6'b100001, 1'b1, 32'h9876_FFFF, 1'b1, 2'd1, 32'h0000_ABCD, bc);
        chk("R4 same-cycle fold", csum_out, m_view());

        // R13: idle hold
        held = csum_out;
        repeat (5) @(negedge clk);
        chk("R13 idle hold", csum_out, held);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule